// File: doc/BRIEF.md
# Privilege-Gated Interrupt Selector

This block decides, in the same cycle, whether a hart should take an interrupt and which cause code it should report. It looks at the pending and enable registers and keeps the interrupts present in both. It then splits those candidates by the delegation mask. Candidates that are not delegated are gated by the machine-level rules. Delegated candidates are gated by the supervisor-level rules. From the combined set, the lowest-numbered interrupt wins.

The block is purely combinational. The trap-entry sequencer samples `take_irq` and `irq_cause` at an instruction boundary. The block has no CSR storage and no interrupt sources of its own; it only arbitrates and gates. The register width `XLEN` is a parameter and may be 32 or 64.

Top module: `intr_selector`

## Requirements
- R1: An interrupt is a candidate only when its bit is set in both `irq_pend` and `irq_enab`. A bit set in only one of the two has no effect on the outputs.
- R2: A candidate whose `irq_deleg` bit is 0 is allowed when `cur_priv` is numerically below 3 (machine). At machine level it is allowed only when `m_gie` is 1.
- R3: A candidate whose `irq_deleg` bit is 1 is allowed when `cur_priv` is 0 (user). At supervisor level (1) it is allowed only when `s_gie` is 1. At machine level (3) it is never allowed.
- R4: The allowed set is the union of the allowed non-delegated candidates and the allowed delegated candidates. Both kinds take part in the same priority pick.
- R5: When several interrupts are allowed, the one with the lowest bit index wins, whether it is delegated or not.
- R6: When an interrupt is taken, `take_irq` is 1. `irq_cause` then has bit XLEN-1 set to 1, the winning index in its low $clog2(XLEN) bits, and every other bit 0. This holds for any index from 0 to XLEN-1.
- R7: When the allowed set is empty, `take_irq` is 0 and `irq_cause` is all zeros.
- R8: The unused privilege code 2 is compared by its numeric value. It therefore allows non-delegated candidates (2 is below 3) and blocks delegated candidates (2 is above 1).
- R9: `s_gie` has no effect on non-delegated candidates, and `m_gie` has no effect on delegated candidates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| irq_pend | input | XLEN | Pending interrupt bits, one per cause index |
| irq_enab | input | XLEN | Per-interrupt enable bits |
| irq_deleg | input | XLEN | Delegation mask; a 1 routes that interrupt to supervisor gating |
| cur_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_gie | input | 1 | Machine global interrupt enable |
| s_gie | input | 1 | Supervisor global interrupt enable |
| take_irq | output | 1 | High when an interrupt is to be taken now |
| irq_cause | output | XLEN | Cause word: interrupt flag in the MSB, winning index in the low bits |

## Verification
The block holds no state. A wrong routing or priority decision therefore shows at the ports in the same evaluation as the input change that caused it. Such a fault appears in one of three ways: a wrong index in `irq_cause`, a take that should have been blocked, or a missing take. The vectors place delegated and non-delegated candidates next to each other, so that a swapped gate or a reversed priority changes the reported index. A walk of a single bit through every index checks that each index is encoded and that the flag sits in bit XLEN-1.

// File: rtl/intr_sel_pkg.sv
package intr_sel_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_MACH  = 2'd3
    } priv_t;

    // Machine-routed interrupts: open below machine level, or at machine
    // level when the machine global enable is set.
    function automatic logic mach_route_open(input logic [1:0] prv, input logic mgie);
        return (prv < PRIV_MACH) || ((prv == PRIV_MACH) && mgie);
    endfunction

    // Supervisor-routed interrupts: open below supervisor level, or at
    // supervisor level when the supervisor global enable is set.
    function automatic logic super_route_open(input logic [1:0] prv, input logic sgie);
        return (prv < PRIV_SUPER) || ((prv == PRIV_SUPER) && sgie);
    endfunction

endpackage

// File: rtl/intr_gate.sv
module intr_gate
    import intr_sel_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] cand,
    input  logic [XLEN-1:0] deleg,
    input  logic [1:0]      prv,
    input  logic            mgie,
    input  logic            sgie,
    output logic [XLEN-1:0] allowed
);

    logic            m_open;
    logic            s_open;
    logic [XLEN-1:0] m_part;
    logic [XLEN-1:0] s_part;

    assign m_open = mach_route_open(prv, mgie);
    assign s_open = super_route_open(prv, sgie);

    genvar g;
    generate
        for (g = 0; g < XLEN; g++) begin : g_bit
            assign m_part[g] = cand[g] & ~deleg[g] & m_open;
            assign s_part[g] = cand[g] &  deleg[g] & s_open;
        end
    endgenerate

    assign allowed = m_part | s_part;

    always_comb begin
        if (prv == PRIV_MACH) begin
            AST_MACH_NO_DELEG: assert ((allowed & deleg) == '0);  // R3
        end
        AST_ALLOWED_SUBSET: assert ((allowed & ~cand) == '0);     // R1
    end

endmodule

// File: rtl/intr_prio.sv
module intr_prio #(
    parameter int XLEN = 64,
    localparam int IDXW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] vec,
    output logic            found,
    output logic [IDXW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = XLEN - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDXW'(i);
            end
        end
    end

    always_comb begin
        for (int j = 0; j < XLEN; j++) begin
            if (found && (j < int'(idx))) begin
                AST_LOWEST_WINS: assert (!vec[j]);  // R5
            end
        end
        if (found) begin
            AST_WINNER_SET: assert (vec[idx]);      // R5
        end
    end

endmodule

// File: rtl/intr_selector.sv
module intr_selector
    import intr_sel_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] irq_pend,
    input  logic [XLEN-1:0] irq_enab,
    input  logic [XLEN-1:0] irq_deleg,
    input  logic [1:0]      cur_priv,
    input  logic            m_gie,
    input  logic            s_gie,
    output logic            take_irq,
    output logic [XLEN-1:0] irq_cause
);

    localparam int IDXW = $clog2(XLEN);
    localparam int PADW = XLEN - 1 - IDXW;

    logic [XLEN-1:0] cand;
    logic [XLEN-1:0] allowed;
    logic            hit;
    logic [IDXW-1:0] win_idx;

    assign cand = irq_pend & irq_enab;

    intr_gate #(.XLEN(XLEN)) u_gate (
        .cand    (cand),
        .deleg   (irq_deleg),
        .prv     (cur_priv),
        .mgie    (m_gie),
        .sgie    (s_gie),
        .allowed (allowed)
    );

    intr_prio #(.XLEN(XLEN)) u_prio (
        .vec   (allowed),
        .found (hit),
        .idx   (win_idx)
    );

    assign take_irq  = hit;
    assign irq_cause = hit ? {1'b1, {PADW{1'b0}}, win_idx} : '0;

    always_comb begin
        AST_FLAG_TRACKS_TAKE: assert (take_irq == irq_cause[XLEN-1]);  // R6
        if (!take_irq) begin
            AST_IDLE_ZERO: assert (irq_cause == '0);                   // R7
        end
        if (take_irq) begin
            AST_WINNER_PENDING: assert (irq_pend[irq_cause[IDXW-1:0]] && irq_enab[irq_cause[IDXW-1:0]]);  // R1
        end
        if ((cur_priv == PRIV_MACH) && !m_gie) begin
            AST_MACH_MASKED: assert (!take_irq);                       // R2
        end
        if ((cur_priv == PRIV_SUPER) && !s_gie && take_irq) begin
            AST_SUPER_MASKED: assert (!irq_deleg[irq_cause[IDXW-1:0]]); // R3
        end
    end

endmodule

// File: tb/test_intr_selector.sv
module test_intr_selector;

    localparam int XLEN = 64;

    typedef struct packed {
        logic [63:0] pend;
        logic [63:0] enab;
        logic [63:0] deleg;
        logic [1:0]  prv;
        logic        mg;
        logic        sg;
        logic        take;
        logic [5:0]  idx;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{64'h80, 64'h80, 64'h0,   2'd3, 1'b1, 1'b0, 1'b1, 6'd7,  4'd2}, // R2 machine, gie on
        '{64'h80, 64'h80, 64'h0,   2'd3, 1'b0, 1'b1, 1'b0, 6'd0,  4'd2}, // R2 machine, gie off
        '{64'h80, 64'h80, 64'h0,   2'd1, 1'b0, 1'b0, 1'b1, 6'd7,  4'd2}, // R2 below machine
        '{64'h22, 64'h22, 64'h2,   2'd1, 1'b0, 1'b0, 1'b1, 6'd5,  4'd3}, // R3 deleg blocked at S
        '{64'h22, 64'h22, 64'h2,   2'd1, 1'b0, 1'b1, 1'b1, 6'd1,  4'd3}, // R3 deleg open at S
        '{64'h22, 64'h22, 64'h2,   2'd3, 1'b1, 1'b1, 1'b1, 6'd5,  4'd3}, // R3 deleg never at M
        '{64'h22, 64'h22, 64'h2,   2'd0, 1'b0, 1'b0, 1'b1, 6'd1,  4'd3}, // R3 user level
        '{64'hF0, 64'h0F, 64'h0,   2'd0, 1'b1, 1'b1, 1'b0, 6'd0,  4'd1}, // R1 no overlap
        '{64'h6,  64'h4,  64'h0,   2'd0, 1'b1, 1'b1, 1'b1, 6'd2,  4'd1}, // R1 bit1 not enabled
        '{64'h300,64'h300,64'h100, 2'd1, 1'b0, 1'b1, 1'b1, 6'd8,  4'd4}, // R4 delegated lower
        '{64'h300,64'h300,64'h200, 2'd1, 1'b0, 1'b1, 1'b1, 6'd8,  4'd4}, // R4 non-deleg lower
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 2'd3, 1'b1, 1'b0, 1'b1, 6'd0, 4'd5}, // R5 all set
        '{64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0, 2'd0, 1'b0, 1'b0, 1'b1, 6'd63, 4'd6}, // R6 top index
        '{64'h22, 64'h22, 64'h2,   2'd2, 1'b0, 1'b1, 1'b1, 6'd5,  4'd8}, // R8 code 2
        '{64'h10, 64'h10, 64'h0,   2'd3, 1'b0, 1'b1, 1'b0, 6'd0,  4'd9}, // R9 s_gie no help at M
        '{64'h4,  64'h4,  64'h4,   2'd1, 1'b1, 1'b0, 1'b0, 6'd0,  4'd9}, // R9 m_gie no help deleg
        '{64'h4,  64'h4,  64'h4,   2'd1, 1'b0, 1'b1, 1'b1, 6'd2,  4'd9}  // R9 deleg needs only s_gie
    };

    logic            clk = 1'b0;
    logic [XLEN-1:0] irq_pend;
    logic [XLEN-1:0] irq_enab;
    logic [XLEN-1:0] irq_deleg;
    logic [1:0]      cur_priv;
    logic            m_gie;
    logic            s_gie;
    logic            take_irq;
    logic [XLEN-1:0] irq_cause;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    intr_selector #(.XLEN(XLEN)) i_intr_selector (
        .irq_pend  (irq_pend),
        .irq_enab  (irq_enab),
        .irq_deleg (irq_deleg),
        .cur_priv  (cur_priv),
        .m_gie     (m_gie),
        .s_gie     (s_gie),
        .take_irq  (take_irq),
        .irq_cause (irq_cause)
    );

    task automatic apply(input logic [63:0] p, input logic [63:0] e, input logic [63:0] d,
                         input logic [1:0] pr, input logic mg, input logic sg);
        @(posedge clk);
        irq_pend  = p;
        irq_enab  = e;
        irq_deleg = d;
        cur_priv  = pr;
        m_gie     = mg;
        s_gie     = sg;
        @(negedge clk);
    endtask

    task automatic expect_out(input logic exp_take, input logic [5:0] exp_idx, input int req);
        logic [63:0] exp_cause;
        exp_cause = exp_take ? ((64'd1 << 63) | 64'(exp_idx)) : 64'd0;
        checks++;
        if (take_irq !== exp_take) begin
            failures++;
            $display("FAIL R%0d take_irq actual=%0b expected=%0b", req, take_irq, exp_take);
        end
        checks++;
        if (irq_cause !== exp_cause) begin
            failures++;
            $display("FAIL R%0d irq_cause actual=%h expected=%h", req, irq_cause, exp_cause);
        end
    endtask

    initial begin
        irq_pend = '0; irq_enab = '0; irq_deleg = '0;
        cur_priv = 2'd3; m_gie = 1'b0; s_gie = 1'b0;

        // R7: quiet inputs give no take and a zero cause
        apply(64'h0, 64'h0, 64'h0, 2'd3, 1'b0, 1'b0);
        expect_out(1'b0, 6'd0, 7);
        // R7: enabled everywhere but nothing pending
        apply(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 2'd0, 1'b1, 1'b1);
        expect_out(1'b0, 6'd0, 7);

        for (int k = 0; k < NV; k++) begin
            apply(VEC[k].pend, VEC[k].enab, VEC[k].deleg, VEC[k].prv, VEC[k].mg, VEC[k].sg);
            expect_out(VEC[k].take, VEC[k].idx, int'(VEC[k].req));
        end

        // R6: a single interrupt at every index encodes its own index
        for (int b = 0; b < XLEN; b++) begin
            apply(64'd1 << b, 64'd1 << b, 64'h0, 2'd0, 1'b0, 1'b0);
            expect_out(1'b1, 6'(b), 6);
        end

        // R5: two interrupts, one delegated, lowest index wins
        apply(64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 2'd0, 1'b0, 1'b0);
        expect_out(1'b1, 6'd0, 5);

        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<5000", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule